// File: doc/BRIEF.md
# Overlapping-Group Opcode Decoder

This block turns an 8-bit opcode of a small accumulator processor into a control word. The control word holds an addressing-mode code, a set of ALU operation flags, operand-source selects and three writeback strobes: accumulator, X register and memory. The opcode space is split by its two low bits into two decoded groups. Group `01` holds the arithmetic and logic operations on the accumulator. Group `10` holds the read-modify-write, shift and X-register operations. Opcodes whose low bits are `00` are outside this decoder and yield an empty word.

Opcodes whose low bits are `11` are not decoded as a group of their own. For these, each control line is the OR of the lines that the group-01 and group-10 decoders produce for the same upper six bits. The combined behaviours come from this union alone, for example load-into-both-registers and decrement-then-compare. No trap or no-op is inserted for them.

The opcode is captured on a valid strobe, and the decoded word appears one clock later. The word is held until the next strobe. The writeback strobes are gated by a last-cycle input from the sequencer, so a register or memory is written only on an instruction's final cycle.

Top module: `ovl_opdec_top`

## Requirements
- R1: After reset (active-low `rst_n`), `dec_valid`, `mode`, `alu_op`, `src_a`, `src_x` and all three strobes read 0.
- R2: When `op_valid` is high at a rising clock edge, the decoded word for `opcode` is visible from that edge on and `dec_valid` is 1. While `op_valid` stays low, `mode`, `alu_op`, `src_a` and `src_x` keep their values.
- R3: `mode` equals opcode bits 4:2. The codes are 0 X-indexed indirect, 1 zero page, 2 immediate, 3 absolute, 4 indirect Y-indexed, 5 zero page X-indexed, 6 absolute Y-indexed and 7 absolute X-indexed.
- R4: `alu_op` bit positions are 0 OR, 1 AND, 2 XOR, 3 add, 4 subtract, 5 compare, 6 pass, 7 shift-left, 8 shift-right, 9 rotate, 10 increment and 11 decrement. For group 01 (bits 1:0 = 01), bits 7:5 select the row:
  - 0 to 3: OR, AND, XOR and add, each writing A.
  - 4: store A to memory (`mem_wr`, `src_a`), in every slot except immediate.
  - 5: pass, writing A.
  - 6: compare, with no write.
  - 7: subtract, writing A.
- R5: For group 10 (bits 1:0 = 10), rows 0 to 3 are shift-left, rotate-left, shift-right and rotate-right. These use slots 1, 3, 5 and 7 on memory (`mem_wr`), and slot 2 on A (`src_a`, `wr_a`). The other rows are:
  - Row 4: store X in slots 1, 3 and 5, and X-to-A transfer (pass, `src_x`, `wr_a`) in slot 2.
  - Row 5: pass into X in slots 0, 1, 3, 5 and 7, and A-to-X transfer (pass, `src_a`, `wr_x`) in slot 2.
  - Row 6: decrement memory in slots 1, 3, 5 and 7, and decrement X (`wr_x`) in slot 2.
  - Row 7: increment memory in slots 1, 3, 5 and 7.
- R6: Opcodes with bits 1:0 = 00 produce an all-zero control word.
- R7: For bits 1:0 = 11, every control output equals the OR of the outputs for the same opcode with bit 1 cleared and with bit 0 cleared.
- R8: Slots left undefined by R4 and R5 produce an all-zero contribution. Examples are 0x89, 0x82, 0x92 and 0xEA.
- R9: `wr_a`, `wr_x` and `mem_wr` are high only while `last_cycle` is 1 and `dec_valid` is 1.
- R10: The following opcodes give these combined words:
  - 0xA7: pass with both `wr_a` and `wr_x`.
  - 0xC7: compare and decrement with `mem_wr`.
  - 0xE7: subtract and increment with `mem_wr` and `wr_a`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| op_valid | input | 1 | Capture `opcode` at this edge |
| opcode | input | 8 | Instruction opcode byte |
| last_cycle | input | 1 | High on the instruction's final cycle |
| dec_valid | output | 1 | A word has been captured since reset |
| mode | output | 3 | Addressing-mode code |
| alu_op | output | 12 | ALU operation flags |
| src_a | output | 1 | Operand taken from A |
| src_x | output | 1 | Operand taken from X |
| wr_a | output | 1 | Accumulator write strobe |
| wr_x | output | 1 | X register write strobe |
| mem_wr | output | 1 | Memory write strobe |

## Verification
All 256 opcodes are driven in turn, and each word is compared with a reference built from the two group tables. The sweep separates a correct union from a priority merge, from a dropped group and from a mis-decoded slot. Directed patterns pick out the three named composites, the undefined slots and the `00` group, which tell a zero default apart from a leftover decode. Holding `op_valid` low and toggling `last_cycle` around a captured word separates correct holding and gating from re-capture and ungated strobes.

// File: rtl/ovl_dec_pkg.sv
// Shared widths, mode codes, ALU flag positions and control-word layout.
// Assumes an 8-bit opcode: bits 7:5 row, bits 4:2 slot, bits 1:0 group.
package ovl_dec_pkg;
    localparam int OP_W   = 8;
    localparam int ROW_W  = 3;
    localparam int SLOT_W = 3;
    localparam int GRP_W  = 2;
    localparam int ALU_W  = 12;

    typedef enum logic [SLOT_W-1:0] {
        AM_XIND = 3'd0, AM_ZP  = 3'd1, AM_IMM  = 3'd2, AM_ABS  = 3'd3,
        AM_INDY = 3'd4, AM_ZPX = 3'd5, AM_ABSY = 3'd6, AM_ABSX = 3'd7
    } amode_e;

    localparam int F_OR   = 0;
    localparam int F_AND  = 1;
    localparam int F_XOR  = 2;
    localparam int F_ADD  = 3;
    localparam int F_SUB  = 4;
    localparam int F_CMP  = 5;
    localparam int F_PASS = 6;
    localparam int F_SHL  = 7;
    localparam int F_SHR  = 8;
    localparam int F_ROT  = 9;
    localparam int F_INC  = 10;
    localparam int F_DEC  = 11;

    typedef struct packed {
        logic [ALU_W-1:0] alu;
        logic             mem_wr;
        logic             src_a;
        logic             src_x;
        logic             wr_a;
        logic             wr_x;
    } ctrl_t;

    localparam int CW = $bits(ctrl_t);
endpackage

// File: rtl/ovl_grp01_dec.sv
// Group-01 decoder: accumulator arithmetic/logic rows.
// Assumes the caller ignores opcode bits 1:0; output is a raw contribution.
module ovl_grp01_dec
    import ovl_dec_pkg::*;
(
    input  logic [ROW_W-1:0]  row,
    input  logic [SLOT_W-1:0] slot,
    output ctrl_t             word
);
    // Map row/slot to the control contribution of this group.
    always_comb begin
        word = '0;
        unique case (row)
            3'd0: begin word.alu[F_OR]  = 1'b1; word.wr_a = 1'b1; end
            3'd1: begin word.alu[F_AND] = 1'b1; word.wr_a = 1'b1; end
            3'd2: begin word.alu[F_XOR] = 1'b1; word.wr_a = 1'b1; end
            3'd3: begin word.alu[F_ADD] = 1'b1; word.wr_a = 1'b1; end
            3'd4: begin
                if (slot != AM_IMM) begin
                    word.mem_wr = 1'b1;
                    word.src_a  = 1'b1;
                end
            end
            3'd5: begin word.alu[F_PASS] = 1'b1; word.wr_a = 1'b1; end
            3'd6: begin word.alu[F_CMP]  = 1'b1; end
            default: begin word.alu[F_SUB] = 1'b1; word.wr_a = 1'b1; end
        endcase
    end
endmodule

// File: rtl/ovl_grp10_dec.sv
// Group-10 decoder: shift/rotate, X transfers, increment/decrement rows.
// Slots 0, 4 and 6 are mostly undefined and leave the word empty.
module ovl_grp10_dec
    import ovl_dec_pkg::*;
(
    input  logic [ROW_W-1:0]  row,
    input  logic [SLOT_W-1:0] slot,
    output ctrl_t             word
);
    logic mem_slot;   // slots 1,3,5,7 address memory
    logic acc_slot;   // slot 2 acts on a register

    // Classify the slot once for all rows.
    always_comb begin
        mem_slot = slot[0];
        acc_slot = (slot == AM_IMM);
    end

    // Build the contribution for the selected row.
    always_comb begin
        word = '0;
        unique case (row)
            3'd0, 3'd1, 3'd2, 3'd3: begin
                if (mem_slot || acc_slot) begin
                    word.alu[F_SHL] = ~row[1];
                    word.alu[F_SHR] = row[1];
                    word.alu[F_ROT] = row[0];
                    word.mem_wr     = mem_slot;
                    word.src_a      = acc_slot;
                    word.wr_a       = acc_slot;
                end
            end
            3'd4: begin
                if (acc_slot) begin
                    word.alu[F_PASS] = 1'b1;
                    word.src_x       = 1'b1;
                    word.wr_a        = 1'b1;
                end else if (slot == AM_ZP || slot == AM_ABS || slot == AM_ZPX) begin
                    word.mem_wr = 1'b1;
                    word.src_x  = 1'b1;
                end
            end
            3'd5: begin
                if (acc_slot) begin
                    word.alu[F_PASS] = 1'b1;
                    word.src_a       = 1'b1;
                    word.wr_x        = 1'b1;
                end else if (mem_slot || slot == AM_XIND) begin
                    word.alu[F_PASS] = 1'b1;
                    word.wr_x        = 1'b1;
                end
            end
            3'd6: begin
                if (acc_slot) begin
                    word.alu[F_DEC] = 1'b1;
                    word.wr_x       = 1'b1;
                end else if (mem_slot) begin
                    word.alu[F_DEC] = 1'b1;
                    word.mem_wr     = 1'b1;
                end
            end
            default: begin
                if (mem_slot) begin
                    word.alu[F_INC] = 1'b1;
                    word.mem_wr     = 1'b1;
                end
            end
        endcase
    end
endmodule

// File: rtl/ovl_union_merge.sv
// Per-line merge: group bit 0 enables the group-01 word, bit 1 the group-10
// word; both set gives their OR, neither gives zero.
module ovl_union_merge
    import ovl_dec_pkg::*;
(
    input  logic [GRP_W-1:0] grp,
    input  logic [CW-1:0]    g01,
    input  logic [CW-1:0]    g10,
    output logic [CW-1:0]    merged
);
    for (genvar i = 0; i < CW; i++) begin : g_line
        // One control line: enabled contributions ORed together.
        assign merged[i] = (grp[0] & g01[i]) | (grp[1] & g10[i]);
    end
endmodule

// File: rtl/ovl_ctrl_reg.sv
// Capture stage: holds the merged word and mode from the last valid strobe.
// Synchronous active-low reset clears everything.
module ovl_ctrl_reg
    import ovl_dec_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [CW-1:0]     word_d,
    input  logic [SLOT_W-1:0] mode_d,
    output logic [CW-1:0]     word_q,
    output logic [SLOT_W-1:0] mode_q,
    output logic              vld_q
);
    // Load on strobe, otherwise hold.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            word_q <= '0;
            mode_q <= '0;
            vld_q  <= 1'b0;
        end else if (load) begin
            word_q <= word_d;
            mode_q <= mode_d;
            vld_q  <= 1'b1;
        end
    end
endmodule

// File: rtl/ovl_opdec_top.sv
// Top of the overlapping-group decoder: two group decoders, a per-line
// union merge, a capture register and last-cycle gating of the strobes.
module ovl_opdec_top
    import ovl_dec_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             op_valid,
    input  logic [OP_W-1:0]  opcode,
    input  logic             last_cycle,
    output logic             dec_valid,
    output logic [2:0]       mode,
    output logic [ALU_W-1:0] alu_op,
    output logic             src_a,
    output logic             src_x,
    output logic             wr_a,
    output logic             wr_x,
    output logic             mem_wr
);
    localparam int ROW_LSB  = SLOT_W + GRP_W;
    localparam int SLOT_LSB = GRP_W;

    logic [ROW_W-1:0]  row;
    logic [SLOT_W-1:0] slot;
    logic [GRP_W-1:0]  grp;
    ctrl_t             g01_w, g10_w, held_w;
    logic [CW-1:0]     merged_w;
    logic [CW-1:0]     held_v;
    logic              gate;

    // Split the opcode into row, slot and group fields.
    always_comb begin
        row  = opcode[ROW_LSB +: ROW_W];
        slot = opcode[SLOT_LSB +: SLOT_W];
        grp  = opcode[GRP_W-1:0];
    end

    ovl_grp01_dec u_g01 (.row(row), .slot(slot), .word(g01_w));
    ovl_grp10_dec u_g10 (.row(row), .slot(slot), .word(g10_w));

    ovl_union_merge u_merge (
        .grp(grp), .g01(g01_w), .g10(g10_w), .merged(merged_w)
    );

    ovl_ctrl_reg u_reg (
        .clk(clk), .rst_n(rst_n), .load(op_valid),
        .word_d(merged_w), .mode_d(slot),
        .word_q(held_v), .mode_q(mode), .vld_q(dec_valid)
    );

    // Drive the held word out, strobes only on the final cycle.
    always_comb begin
        held_w = ctrl_t'(held_v);
        gate   = last_cycle & dec_valid;
        alu_op = held_w.alu;
        src_a  = held_w.src_a;
        src_x  = held_w.src_x;
        wr_a   = held_w.wr_a   & gate;
        wr_x   = held_w.wr_x   & gate;
        mem_wr = held_w.mem_wr & gate;
    end
endmodule

// File: rtl/ovl_opdec_chk.sv
// Checker for ovl_opdec_top, attached by bind; observes ports and the
// group decoder outputs.
module ovl_opdec_chk
    import ovl_dec_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic             op_valid,
    input logic [OP_W-1:0]  opcode,
    input logic             last_cycle,
    input logic             dec_valid,
    input logic [2:0]       mode,
    input logic [ALU_W-1:0] alu_op,
    input logic             src_a,
    input logic             src_x,
    input logic             wr_a,
    input logic             wr_x,
    input logic             mem_wr,
    input logic [CW-1:0]    g01_v,
    input logic [CW-1:0]    g10_v,
    input logic [CW-1:0]    merged_w
);
    p_capture_valid_r2: assert property (@(posedge clk) disable iff (!rst_n)
        op_valid |=> dec_valid);

    p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!op_valid && dec_valid) |=> ($stable(alu_op) && $stable(mode)
                                      && $stable(src_a) && $stable(src_x)));

    p_mode_field_r3: assert property (@(posedge clk) disable iff (!rst_n)
        op_valid |=> (mode == $past(opcode[4:2])));

    p_low00_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && opcode[1:0] == 2'b00) |=> (alu_op == '0 && !src_a && !src_x
                                                && !wr_a && !wr_x && !mem_wr));

    p_union_lines_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (opcode[1:0] == 2'b11) |-> (merged_w == (g01_v | g10_v)));

    p_strobe_gate_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_a || wr_x || mem_wr) |-> (last_cycle && dec_valid));

    p_no_strobe_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !last_cycle |-> !(wr_a || wr_x || mem_wr));
endmodule

bind ovl_opdec_top ovl_opdec_chk u_chk (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .opcode(opcode),
    .last_cycle(last_cycle), .dec_valid(dec_valid), .mode(mode),
    .alu_op(alu_op), .src_a(src_a), .src_x(src_x), .wr_a(wr_a),
    .wr_x(wr_x), .mem_wr(mem_wr), .g01_v(g01_w), .g10_v(g10_w),
    .merged_w(merged_w)
);

// File: tb/tb_ovl_opdec_top.sv
// Directed bench: one task per scenario, each checking its own results.
module tb_ovl_opdec_top;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        op_valid = 1'b0;
    logic [7:0]  opcode = 8'h00;
    logic        last_cycle = 1'b0;
    logic        dec_valid;
    logic [2:0]  mode;
    logic [11:0] alu_op;
    logic        src_a, src_x, wr_a, wr_x, mem_wr;

    int n_chk = 0;
    int n_bad = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    ovl_opdec_top dut (
        .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .opcode(opcode),
        .last_cycle(last_cycle), .dec_valid(dec_valid), .mode(mode),
        .alu_op(alu_op), .src_a(src_a), .src_x(src_x), .wr_a(wr_a),
        .wr_x(wr_x), .mem_wr(mem_wr)
    );

    // Packed observation: {alu[11:0], mem_wr, src_a, src_x, wr_a, wr_x}
    function automatic logic [16:0] pk(input logic [11:0] a, input logic m,
                                       input logic sa, input logic sx,
                                       input logic wa, input logic wx);
        return {a, m, sa, sx, wa, wx};
    endfunction

    function automatic logic [11:0] fl(input int b);
        return 12'(1) << b;
    endfunction

    // Reference for group-01 rows from R4.
    function automatic logic [16:0] ref01(input int r, input int s);
        case (r)
            0: return pk(fl(0), 0, 0, 0, 1, 0);
            1: return pk(fl(1), 0, 0, 0, 1, 0);
            2: return pk(fl(2), 0, 0, 0, 1, 0);
            3: return pk(fl(3), 0, 0, 0, 1, 0);
            4: return (s == 2) ? 17'd0 : pk(12'd0, 1, 1, 0, 0, 0);
            5: return pk(fl(6), 0, 0, 0, 1, 0);
            6: return pk(fl(5), 0, 0, 0, 0, 0);
            default: return pk(fl(4), 0, 0, 0, 1, 0);
        endcase
    endfunction

    // Reference for group-10 rows from R5 and R8.
    function automatic logic [16:0] ref10(input int r, input int s);
        logic memslot = (s == 1 || s == 3 || s == 5 || s == 7);
        logic [11:0] sh;
        if (r < 4) begin
            sh = ((r >= 2) ? fl(8) : fl(7)) | ((r % 2 == 1) ? fl(9) : 12'd0);
            if (memslot) return pk(sh, 1, 0, 0, 0, 0);
            if (s == 2)  return pk(sh, 0, 1, 0, 1, 0);
            return 17'd0;
        end
        if (r == 4) begin
            if (s == 2) return pk(fl(6), 0, 0, 1, 1, 0);
            if (s == 1 || s == 3 || s == 5) return pk(12'd0, 1, 0, 1, 0, 0);
            return 17'd0;
        end
        if (r == 5) begin
            if (s == 2) return pk(fl(6), 0, 1, 0, 0, 1);
            if (memslot || s == 0) return pk(fl(6), 0, 0, 0, 0, 1);
            return 17'd0;
        end
        if (r == 6) begin
            if (s == 2) return pk(fl(11), 0, 0, 0, 0, 1);
            if (memslot) return pk(fl(11), 1, 0, 0, 0, 0);
            return 17'd0;
        end
        if (memslot) return pk(fl(10), 1, 0, 0, 0, 0);
        return 17'd0;
    endfunction

    // Union model from R6/R7.
    function automatic logic [16:0] ref_word(input logic [7:0] op);
        logic [16:0] w = 17'd0;
        if (op[0]) w = w | ref01(int'(op[7:5]), int'(op[4:2]));
        if (op[1]) w = w | ref10(int'(op[7:5]), int'(op[4:2]));
        return w;
    endfunction

    function automatic logic [16:0] seen();
        return pk(alu_op, mem_wr, src_a, src_x, wr_a, wr_x);
    endfunction

    task automatic check(input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Present an opcode with a strobe; outputs settle after the next edge.
    task automatic issue(input logic [7:0] op);
        @(negedge clk);
        opcode = op; op_valid = 1'b1; last_cycle = 1'b1;
        @(negedge clk);
        op_valid = 1'b0;
    endtask

    task automatic t_reset();
        check("R1 dec_valid", 32'(dec_valid), 0);
        check("R1 word", 32'(seen()), 0);
        check("R1 mode", 32'(mode), 0);
    endtask

    task automatic t_sweep();
        for (int i = 0; i < 256; i++) begin
            issue(8'(i));
            check($sformatf("R7 R4 R5 op %02h", i), 32'(seen()), 32'(ref_word(8'(i))));
            check($sformatf("R3 mode op %02h", i), 32'(mode), 32'(i[4:2]));
        end
    endtask

    task automatic t_composites();
        issue(8'hA7);
        check("R10 A7", 32'(seen()), 32'(pk(fl(6), 0, 0, 0, 1, 1)));
        issue(8'hC7);
        check("R10 C7", 32'(seen()), 32'(pk(fl(5) | fl(11), 1, 0, 0, 0, 0)));
        issue(8'hE7);
        check("R10 E7", 32'(seen()), 32'(pk(fl(4) | fl(10), 1, 0, 0, 1, 0)));
    endtask

    task automatic t_undefined();
        issue(8'h89);
        check("R8 89", 32'(seen()), 0);
        issue(8'h82);
        check("R8 82", 32'(seen()), 0);
        issue(8'h92);
        check("R8 92", 32'(seen()), 0);
        issue(8'hEA);
        check("R8 EA", 32'(seen()), 0);
        issue(8'hAC);
        check("R6 AC", 32'(seen()), 0);
    endtask

    task automatic t_hold_gate();
        issue(8'hA9);
        opcode = 8'h00;
        repeat (3) @(negedge clk);
        check("R2 hold word", 32'(seen()), 32'(pk(fl(6), 0, 0, 0, 1, 0)));
        check("R2 hold mode", 32'(mode), 2);
        check("R2 valid", 32'(dec_valid), 1);
        last_cycle = 1'b0;
        #1;
        check("R9 wr_a gated", 32'(wr_a), 0);
        check("R9 alu kept", 32'(alu_op), 32'(fl(6)));
        issue(8'hCE);
        last_cycle = 1'b0;
        #1;
        check("R9 mem_wr gated", 32'(mem_wr), 0);
        last_cycle = 1'b1;
        #1;
        check("R9 mem_wr on last", 32'(mem_wr), 1);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_sweep();
        t_composites();
        t_undefined();
        t_hold_gate();
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule